// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is the target side of a two-wire serial bus with 7-bit addressing. It runs on the system clock and oversamples the bus lines. It passes both lines through a synchroniser and finds START, STOP and clock edges from the synchronised values. It drives the open-drain lines through active-high output enables: an enable of 1 pulls the line low.

A host reads and writes the block through a single data register and a few status bits: a full flag, an overflow flag, an event flag and a clock-release bit. Each bit has strobe inputs that set or clear it. A bus write fills the data register only when the host has emptied it. A byte that arrives while the register is occupied, or while an earlier overflow has not been cleared, is refused with a not-acknowledge.

For a bus read, the block holds the clock line low until the host has loaded the data register and set the release bit. It then shifts the byte out.

Top module: `i2c_target`

## Requirements
- R1: After reset, both output enables are 0 and the full, overflow, event and release flags read 0.
- R2: A received data byte that finishes while full=0 and overflow=0 is copied into the data register. The block sets full and the event flag, and pulls SDA low for the 9th (acknowledge) clock.
- R3: A received data byte that finishes while full=1 leaves the data register unchanged and gets a not-acknowledge: SDA stays released on the 9th clock. The block sets the overflow flag and the event flag.
- R4: A received data byte that finishes while overflow=1 and full=0 is also refused: the data register is not loaded and SDA stays released on the 9th clock. The event flag is still set.
- R5: A one-cycle host read strobe clears full. The overflow flag is cleared only by its clear strobe and the event flag only by its clear strobe; neither is cleared by a read.
- R6: The address byte consists of the 7 address bits, most significant bit first, followed by the direction bit (1 = read). On a match the block acknowledges on the 9th clock and sets the event flag.
- R7: On an address mismatch the block sends no acknowledge and keeps both lines released. It changes no flag and does not load the data register until the next START or STOP.
- R8: After an acknowledged read address, the block clears the release bit and holds SCL low. The hold lasts until the host sets the release bit, even when the master has released SCL.
- R9: When the release bit is set, the block takes the data register, clears full and releases SCL, then shifts the byte out most significant bit first. If the master acknowledges, the block stretches SCL again with the release bit cleared and the event flag set.
- R10: A not-acknowledge from the master after a transmitted byte ends the read. SDA and SCL stay released, and there is no further stretching.
- R11: A STOP returns the block to idle with both lines released. A repeated START restarts the address phase.
- R12: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_wr | input | 1 | Write strobe for the data register, sets full |
| host_wdata | input | 8 | Data written by the host |
| host_rd | input | 1 | Read strobe, clears full |
| host_clr_ovf | input | 1 | Clears the overflow flag |
| host_clr_evt | input | 1 | Clears the event flag |
| host_set_rel | input | 1 | Sets the clock-release bit |
| buf_data | output | 8 | Data register contents |
| buf_full | output | 1 | Full flag |
| ovf_flag | output | 1 | Overflow flag |
| evt_flag | output | 1 | Event flag |
| rel_flag | output | 1 | Clock-release bit |

## Verification
A wrong bit count or a wrong full/overflow decision shows up as a wrong acknowledge level within the same byte. It also shows as a data register or flag that disagrees with the host model once that byte's 9th clock has passed. A missed stretch shows within a few tens of system clocks after the read address, because the master sees SCL rise before the host has released it. A wrong shift order shows as a corrupted byte at the end of the first transmitted byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_HOLD, ST_TX, ST_TACK, ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          evt_set,
  input  logic          tx_take,
  input  logic          rel_clr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          host_clr_ovf,
  input  logic          host_clr_evt,
  input  logic          host_set_rel,
  output logic          ack_ok,
  output logic [DW-1:0] buf_q,
  output logic          full_q,
  output logic          ovf_q,
  output logic          evt_q,
  output logic          rel_q
);
  logic [DW-1:0] buf_d;
  logic full_d, ovf_d, evt_d, rel_d, load;

  assign ack_ok = ~full_q & ~ovf_q;
  assign load   = byte_done & ack_ok;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    evt_d  = evt_q;
    rel_d  = rel_q;
    if (load) begin
      buf_d  = rx_byte;
      full_d = 1'b1;
    end else if (tx_take) begin
      full_d = 1'b0;
    end else if (host_wr) begin
      buf_d  = host_wdata;
      full_d = 1'b1;
    end else if (host_rd) begin
      full_d = 1'b0;
    end
    if (byte_done && full_q) ovf_d = 1'b1;
    else if (host_clr_ovf)   ovf_d = 1'b0;
    if (byte_done || evt_set) evt_d = 1'b1;
    else if (host_clr_evt)    evt_d = 1'b0;
    if (rel_clr)           rel_d = 1'b0;
    else if (host_set_rel) rel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      evt_q  <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      evt_q  <= evt_d;
      rel_q  <= rel_d;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !full_q && !ovf_q) |=> (full_q && evt_q && buf_q == $past(rx_byte)));
  assert_full_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full_q) |=> (ovf_q && evt_q));
  assert_ovf_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ovf_q && !full_q && !host_wr) |=> ($stable(buf_q) && !full_q));
  assert_read_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !byte_done && !host_wr) |=> !full_q);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !host_clr_ovf) |=> ovf_q);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         DW   = 8,
  parameter logic [6:0] ADDR = 7'h42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          ack_ok,
  input  logic          rel_i,
  input  logic [DW-1:0] buf_i,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          evt_set,
  output logic          tx_take,
  output logic          rel_clr,
  output logic          sda_oe_q,
  output logic          scl_oe_q
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  tgt_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          rd_q, rd_d, sda_oe_d, scl_oe_d;

  assign rx_byte = sh_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    rd_d      = rd_q;
    sda_oe_d  = sda_oe_q;
    scl_oe_d  = scl_oe_q;
    byte_done = 1'b0;
    evt_set   = 1'b0;
    tx_take   = 1'b0;
    rel_clr   = 1'b0;
    if (stop_det) begin
      state_d  = ST_IDLE;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
    end else if (start_det) begin
      state_d  = ST_ADDR;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q < LAST) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (state_q == ST_RX) begin
              byte_done = 1'b1;
              sda_oe_d  = ack_ok;
              state_d   = ST_ACK;
            end else if (sh_q[DW-1:DW-7] == ADDR) begin
              evt_set  = 1'b1;
              rd_d     = sh_q[0];
              sda_oe_d = 1'b1;
              state_d  = ST_ACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe_d = 1'b0;
            cnt_d    = '0;
            if (rd_q) begin
              scl_oe_d = 1'b1;
              rel_clr  = 1'b1;
              state_d  = ST_HOLD;
            end else begin
              state_d = ST_RX;
            end
          end
        end
        ST_HOLD: begin
          if (rel_i) begin
            sh_d     = buf_i;
            tx_take  = 1'b1;
            sda_oe_d = ~buf_i[DW-1];
            scl_oe_d = 1'b0;
            cnt_d    = '0;
            state_d  = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              sda_oe_d = 1'b0;
              state_d  = ST_TACK;
            end else begin
              sh_d     = {sh_q[DW-2:0], 1'b0};
              sda_oe_d = ~sh_q[DW-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_SKIP;
          end else if (scl_fall) begin
            evt_set  = 1'b1;
            rel_clr  = 1'b1;
            scl_oe_d = 1'b1;
            state_d  = ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_q     <= 1'b0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rd_q     <= rd_d;
      sda_oe_q <= sda_oe_d;
      scl_oe_q <= scl_oe_d;
    end
  end

  assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !$past(scl_s));
  assert_hold_until_rel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !rel_i && !start_det && !stop_det) |=> scl_oe_q);
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && rel_i && !start_det && !stop_det) |=> (!scl_oe_q && state_q == ST_TX));
  assert_refuse_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ack_ok) |=> !sda_oe_q);
  assert_skip_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!sda_oe_q && !scl_oe_q));
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR        = 7'h42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          host_clr_ovf,
  input  logic          host_clr_evt,
  input  logic          host_set_rel,
  output logic [DW-1:0] buf_data,
  output logic          buf_full,
  output logic          ovf_flag,
  output logic          evt_flag,
  output logic          rel_flag
);
  logic [1:0] rst_pipe;
  logic rst_s_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ack_ok, byte_done, evt_set, tx_take, rel_clr;
  logic [DW-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_tgt_fsm #(.DW(DW), .ADDR(ADDR)) fsm_i (
    .clk(clk), .rst_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .ack_ok(ack_ok), .rel_i(rel_flag), .buf_i(buf_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .evt_set(evt_set),
    .tx_take(tx_take), .rel_clr(rel_clr), .sda_oe_q(sda_oe), .scl_oe_q(scl_oe));

  i2c_tgt_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_s_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .evt_set(evt_set), .tx_take(tx_take), .rel_clr(rel_clr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_clr_ovf(host_clr_ovf), .host_clr_evt(host_clr_evt),
    .host_set_rel(host_set_rel), .ack_ok(ack_ok), .buf_q(buf_data),
    .full_q(buf_full), .ovf_q(ovf_flag), .evt_q(evt_flag), .rel_q(rel_flag));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_s_n |-> (!sda_oe && !scl_oe));
endmodule

// File: tb/i2c_target_tb_top.sv
module i2c_target_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [6:0] ADDR = 7'h42;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl_low, m_sda_low;
  logic scl_oe, sda_oe;
  logic host_wr, host_rd, host_clr_ovf, host_clr_evt, host_set_rel;
  logic [7:0] host_wdata, buf_data;
  logic buf_full, ovf_flag, evt_flag, rel_flag;
  logic scl_line, sda_line;
  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  int r12_viol = 0;
  bit finished = 1'b0;
  logic prev_sda_oe, prev_scl;

  always #2.5 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_target #(.ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_clr_ovf(host_clr_ovf), .host_clr_evt(host_clr_evt),
    .host_set_rel(host_set_rel), .buf_data(buf_data), .buf_full(buf_full),
    .ovf_flag(ovf_flag), .evt_flag(evt_flag), .rel_flag(rel_flag));

  function automatic bit exp_ack(bit full, bit ovf);
    return !full && !ovf;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    m_sda_low = !b;
    wait_clks(HALF);
    scl_up();
    wait_clks(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic recv_bit(output bit b);
    m_sda_low = 1'b0;
    wait_clks(HALF);
    scl_up();
    wait_clks(HALF / 2);
    b = sda_line;
    wait_clks(HALF / 2);
    m_scl_low = 1'b1;
  endtask

  task automatic do_start();
    m_sda_low = 1'b1;
    wait_clks(HALF);
    m_scl_low = 1'b1;
    wait_clks(HALF);
  endtask

  task automatic do_rstart();
    m_sda_low = 1'b0;
    wait_clks(HALF);
    scl_up();
    wait_clks(HALF);
    m_sda_low = 1'b1;
    wait_clks(HALF);
    m_scl_low = 1'b1;
    wait_clks(HALF);
  endtask

  task automatic do_stop();
    m_sda_low = 1'b1;
    wait_clks(HALF);
    scl_up();
    wait_clks(HALF);
    m_sda_low = 1'b0;
    wait_clks(HALF);
  endtask

  task automatic write_byte(logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(s);
    acked = !s;
  endtask

  task automatic read_byte(output logic [7:0] b, input bit give_ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(s);
      b[i] = s;
    end
    send_bit(!give_ack);
    m_sda_low = 1'b0;
  endtask

  task automatic pulse(int which, logic [7:0] d);
    host_wdata = d;
    case (which)
      0: host_wr = 1'b1;
      1: host_rd = 1'b1;
      2: host_clr_ovf = 1'b1;
      3: host_clr_evt = 1'b1;
      default: host_set_rel = 1'b1;
    endcase
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_clr_ovf = 1'b0;
    host_clr_evt = 1'b0; host_set_rel = 1'b0;
    wait_clks(2);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (sda_oe !== prev_sda_oe && prev_scl === 1'b1) r12_viol++;
    end
    prev_sda_oe = sda_oe;
    prev_scl = scl_line;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000 && !finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack, mfull, movf;
    logic [7:0] mbuf, b, rb;
    int seed;
    seed = $urandom(32'h1234);
    rst_n = 1'b0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; host_clr_ovf = 1'b0;
    host_clr_evt = 1'b0; host_set_rel = 1'b0; host_wdata = '0;
    wait_clks(10);
    rst_n = 1'b1;
    wait_clks(6);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 full", buf_full, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 evt", evt_flag, 0);
    chk("R1 rel", rel_flag, 0);

    // R7 address mismatch: ignored
    do_start();
    write_byte({7'h11, 1'b0}, ack);
    chk("R7 no ack on mismatch", ack, 0);
    write_byte(8'h55, ack);
    chk("R7 data ignored", ack, 0);
    chk("R7 evt unchanged", evt_flag, 0);
    chk("R7 full unchanged", buf_full, 0);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);
    do_stop();

    // R6 matching write address
    do_start();
    write_byte({ADDR, 1'b0}, ack);
    chk("R6 address ack", ack, 1);
    chk("R6 evt set", evt_flag, 1);
    pulse(3, 0);
    chk("R5 evt cleared by strobe", evt_flag, 0);

    // directed R2/R3/R4
    write_byte(8'hA7, ack);
    chk("R2 ack", ack, 1);
    chk("R2 data", buf_data, 8'hA7);
    chk("R2 full", buf_full, 1);
    chk("R2 evt", evt_flag, 1);
    pulse(3, 0);
    write_byte(8'h19, ack);
    chk("R3 nack when full", ack, 0);
    chk("R3 ovf", ovf_flag, 1);
    chk("R3 data kept", buf_data, 8'hA7);
    chk("R3 evt", evt_flag, 1);
    pulse(1, 0);
    chk("R5 read clears full", buf_full, 0);
    chk("R5 read keeps ovf", ovf_flag, 1);
    chk("R5 read keeps evt", evt_flag, 1);
    pulse(3, 0);
    write_byte(8'h6E, ack);
    chk("R4 nack with ovf", ack, 0);
    chk("R4 data kept", buf_data, 8'hA7);
    chk("R4 full stays clear", buf_full, 0);
    chk("R4 evt", evt_flag, 1);
    pulse(2, 0);
    chk("R5 ovf cleared by strobe", ovf_flag, 0);
    pulse(3, 0);

    // random bytes against the host model (R2 R3 R4 R5)
    mfull = 1'b0; movf = 1'b0; mbuf = 8'hA7;
    for (int it = 0; it < 40; it++) begin
      int act;
      bit e;
      act = $urandom % 4;
      if (act == 0) begin pulse(1, 0); mfull = 1'b0; end
      else if (act == 1) begin pulse(2, 0); movf = 1'b0; end
      if ($urandom % 2 == 0) pulse(3, 0);
      b = 8'($urandom);
      e = exp_ack(mfull, movf);
      write_byte(b, ack);
      if (e) begin mfull = 1'b1; mbuf = b; end
      else if (mfull) movf = 1'b1;
      chk(e ? "R2 rand ack" : (mfull && !movf ? "R3 rand ack" : "R3/R4 rand ack"), ack, e);
      chk("R2 rand data", buf_data, mbuf);
      chk("R3 rand ovf", ovf_flag, movf);
      chk("R5 rand full", buf_full, mfull);
      chk("R4 rand evt", evt_flag, 1);
    end

    // R11 repeated start restarts address phase
    do_rstart();
    write_byte({7'h15, 1'b0}, ack);
    chk("R11 rstart address phase", ack, 0);
    do_stop();
    chk("R11 released after stop", {scl_oe, sda_oe}, 0);

    // read transfer R8 R9 R10
    pulse(1, 0); pulse(2, 0); pulse(3, 0);
    do_start();
    write_byte({ADDR, 1'b1}, ack);
    chk("R6 read address ack", ack, 1);
    wait_clks(40);
    chk("R8 stretch", scl_oe, 1);
    chk("R8 rel cleared", rel_flag, 0);
    chk("R6 evt on read match", evt_flag, 1);
    m_scl_low = 1'b0;
    wait_clks(30);
    chk("R8 scl held low", scl_line, 0);
    pulse(0, 8'hA5);
    chk("R9 write sets full", buf_full, 1);
    wait_clks(20);
    chk("R8 still held", scl_line, 0);
    pulse(3, 0);
    m_scl_low = 1'b1;
    pulse(4, 0);
    chk("R9 released", scl_oe, 0);
    chk("R9 full cleared", buf_full, 0);
    read_byte(rb, 1'b1);
    chk("R9 byte out", rb, 8'hA5);
    wait_clks(40);
    chk("R9 stretch again", scl_oe, 1);
    chk("R9 rel cleared", rel_flag, 0);
    chk("R9 evt", evt_flag, 1);
    pulse(0, 8'h3C);
    pulse(4, 0);
    read_byte(rb, 1'b0);
    chk("R9 second byte", rb, 8'h3C);
    wait_clks(40);
    chk("R10 no stretch", scl_oe, 0);
    chk("R10 sda released", sda_oe, 0);
    do_stop();
    chk("R11 idle after stop", {scl_oe, sda_oe}, 0);

    chk("R12 sda changes only with scl low", r12_viol, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule